// File: doc/BRIEF.md
# Bit-Serial Signed Sequential Multiplier

This block multiplies a signed N-bit multiplicand by a signed M-bit multiplier and returns a signed (N+M)-bit product. It spends one clock on each multiplier bit. The datapath is an unsigned shift-and-add loop built from a single adder/subtractor and a right-shifting product register. The datapath never sees a signed multiplier. When the multiplier is negative, its magnitude is produced one bit per cycle by a serial two's-complement negation, and the multiplicand is subtracted rather than added. For each bit, the multiplier's sign and its magnitude bit together choose one of three actions: add the multiplicand, subtract it, or leave the partial product unchanged.

Operands enter through a valid/ready handshake. The block takes the pair `mcand`/`mplier` on a clock edge where both `in_valid` and `in_ready` are high. The only back-pressure is `in_ready`, which stays low for the whole computation. A source that holds `in_valid` high keeps its operands pending until the block is free again. The result side has no back-pressure. `done` pulses for one cycle when `product` has been updated, and `product` then holds that value until the next completion. The block can accept a new pair in the same cycle that `done` is high, so back-to-back operations run with no idle cycle.

Top module: `bsmul`

## Requirements
- R1: An operand pair is captured only on an edge where `in_valid` and `in_ready` are both high. `in_ready` is high exactly when `busy` is low.
- R2: After the capture edge, `busy` is high for exactly M consecutive cycles.
- R3: `done` is high for exactly one cycle. That cycle is the first cycle after `busy` falls, which is M edges after the capture edge.
- R4: In the `done` cycle, `product` equals the two's-complement product of the captured `mcand` and `mplier`, as an (N+M)-bit signed value.
- R5: A multiplier equal to -2^(M-1) gives the correct product, including when the multiplicand is also at its most negative value.
- R6: A multiplicand equal to -2^(N-1) gives the correct product for positive, negative and zero multipliers.
- R7: Changes on `mcand`, `mplier` or `in_valid` while `busy` is high have no effect on the product being computed.
- R8: `product` changes only in a cycle where `done` is high, and it holds its value otherwise.
- R9: A pair offered during the `done` cycle is captured on the next edge, and its result follows M cycles after that.
- R10: After reset, `busy` and `done` are low, `in_ready` is high and `product` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can capture a pair (idle) |
| mcand | input | N | Signed multiplicand |
| mplier | input | M | Signed multiplier |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse: `product` updated |
| product | output | N+M | Signed product, held between completions |

## Verification
The bench builds two instances. The first uses the default 16x16 configuration and is driven with random pairs, the signed corner values 0, 1, -1, maximum positive and most negative, an operand change while busy, and a back-to-back hand-over. The second is built asymmetric, with N=5 and M=3. That size makes an exhaustive sweep of all 256 operand pairs affordable. The sweep covers every combination of sign, every serial-negation borrow pattern and both most-negative values. A mismatch between the multiplicand and multiplier widths would show up there as well.

// File: rtl/bsmul_pkg.sv
package bsmul_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;
endpackage

// File: rtl/bsmul_seq.sv
module bsmul_seq
  import bsmul_pkg::*;
#(
  parameter int M = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  output logic step,
  output logic last,
  output logic done
);
  localparam int CW = $clog2(M + 1);

  phase_t        phase;
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      left  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase <= PH_RUN;
            left  <= CW'(M - 1);
          end
        end
        default: begin
          if (left == '0) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            left <= left - 1'b1;
          end
        end
      endcase
    end
  end

  assign step = (phase == PH_RUN);
  assign last = step && (left == '0);
endmodule

// File: rtl/bsmul_negser.sv
module bsmul_negser #(
  parameter int M = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [M-1:0] mplier_in,
  output logic         neg,
  output logic         mag_bit
);
  logic [M-1:0] bits;
  logic         carry;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits  <= '0;
      neg   <= 1'b0;
      carry <= 1'b0;
    end else if (load) begin
      bits  <= mplier_in;
      neg   <= mplier_in[M-1];
      carry <= 1'b1;
    end else if (step) begin
      bits  <= bits >> 1;
      carry <= carry & ~bits[0];
    end
  end

  // Serial ~x + 1: each output bit is the inverted input bit plus the incoming carry.
  assign mag_bit = neg ? (~bits[0] ^ carry) : bits[0];
endmodule

// File: rtl/bsmul_acc.sv
module bsmul_acc #(
  parameter int N = 16,
  parameter int M = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic           last,
  input  logic [N-1:0]   mcand_in,
  input  logic           neg,
  input  logic           mag_bit,
  output logic [N+M-1:0] product
);
  localparam int HW = N + 1;
  localparam int SW = N + 2;

  logic [N-1:0]   mc;
  logic [HW-1:0]  hi;
  logic [M-1:0]   lo;
  logic [SW-1:0]  hi_ext, addend, sum;
  logic [M:0]     lo_cat;
  logic [M-1:0]   lo_next;
  logic [HW+M-1:0] full;

  always_comb begin
    hi_ext  = {hi[HW-1], hi};
    addend  = mag_bit ? {{2{mc[N-1]}}, mc} : '0;
    sum     = neg ? (hi_ext - addend) : (hi_ext + addend);
    lo_cat  = {sum[0], lo};
    lo_next = lo_cat[M:1];
    full    = {sum[SW-1:1], lo_next};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mc      <= '0;
      hi      <= '0;
      lo      <= '0;
      product <= '0;
    end else if (load) begin
      mc <= mcand_in;
      hi <= '0;
      lo <= '0;
    end else if (step) begin
      hi <= sum[SW-1:1];
      lo <= lo_next;
      if (last) product <= full[N+M-1:0];
    end
  end
endmodule

// File: rtl/bsmul.sv
module bsmul #(
  parameter int N = 16,
  parameter int M = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [N-1:0]   mcand,
  input  logic [M-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [N+M-1:0] product
);
  logic accept, step, last, neg, mag_bit;

  assign in_ready = ~step;
  assign busy     = step;
  assign accept   = in_valid & in_ready;

  bsmul_seq #(.M(M)) u_seq (
    .clk(clk), .rst(rst), .accept(accept),
    .step(step), .last(last), .done(done)
  );

  bsmul_negser #(.M(M)) u_neg (
    .clk(clk), .rst(rst), .load(accept), .step(step),
    .mplier_in(mplier), .neg(neg), .mag_bit(mag_bit)
  );

  bsmul_acc #(.N(N), .M(M)) u_acc (
    .clk(clk), .rst(rst), .load(accept), .step(step), .last(last),
    .mcand_in(mcand), .neg(neg), .mag_bit(mag_bit), .product(product)
  );
endmodule

// File: rtl/bsmul_chk.sv
module bsmul_chk #(
  parameter int N = 16,
  parameter int M = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           in_ready,
  input logic [N-1:0]   mcand,
  input logic [M-1:0]   mplier,
  input logic           busy,
  input logic           done,
  input logic [N+M-1:0] product
);
  localparam int BW = $clog2(M + 2);

  logic [BW-1:0] run_len;
  logic          zero_op;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len <= '0;
      zero_op <= 1'b0;
    end else begin
      run_len <= busy ? run_len + 1'b1 : '0;
      if (in_valid && in_ready) zero_op <= (mcand == '0) || (mplier == '0);
    end
  end

  a_r1_capture_starts: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> busy);

  a_r2_busy_len: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == BW'(M)));

  a_r2_busy_cap: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_len < BW'(M)));

  a_r3_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_product_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(product));

  a_r4_zero_operand: assert property (@(posedge clk) disable iff (rst)
    (done && zero_op) |-> (product == '0));
endmodule

bind bsmul bsmul_chk #(.N(N), .M(M)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .mcand(mcand), .mplier(mplier), .busy(busy), .done(done), .product(product)
);

// File: tb/bsmul_test.sv
module bsmul_ref #(
  parameter int N = 16,
  parameter int M = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [N-1:0]   a,
  input  logic [M-1:0]   b,
  output logic           e_busy,
  output logic           e_done,
  output logic [N+M-1:0] e_prod
);
  logic signed [N+M-1:0] pend;
  int remaining;

  always @(posedge clk) begin
    if (rst) begin
      e_busy <= 1'b0; e_done <= 1'b0; e_prod <= '0; remaining <= 0; pend <= '0;
    end else begin
      e_done <= 1'b0;
      if (!e_busy && in_valid) begin
        e_busy    <= 1'b1;
        remaining <= M;
        pend      <= $signed(a) * $signed(b);
      end else if (e_busy) begin
        if (remaining == 1) begin
          e_busy <= 1'b0;
          e_done <= 1'b1;
          e_prod <= pend;
        end
        remaining <= remaining - 1;
      end
    end
  end
endmodule

module bsmul_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit timed_out = 0;

  // 16x16 instance
  logic        v1 = 0;
  logic [15:0] a1 = '0, b1 = '0;
  logic        rdy1, busy1, done1;
  logic [31:0] prod1;
  logic        eb1, ed1;
  logic [31:0] ep1;

  // 5x3 instance
  logic        v2 = 0;
  logic [4:0]  a2 = '0;
  logic [2:0]  b2 = '0;
  logic        rdy2, busy2, done2;
  logic [7:0]  prod2;
  logic        eb2, ed2;
  logic [7:0]  ep2;

  bsmul #(.N(16), .M(16)) uut (
    .clk(clk), .rst(rst), .in_valid(v1), .in_ready(rdy1), .mcand(a1), .mplier(b1),
    .busy(busy1), .done(done1), .product(prod1)
  );
  bsmul_ref #(.N(16), .M(16)) ref1 (
    .clk(clk), .rst(rst), .in_valid(v1), .a(a1), .b(b1),
    .e_busy(eb1), .e_done(ed1), .e_prod(ep1)
  );

  bsmul #(.N(5), .M(3)) uut_small (
    .clk(clk), .rst(rst), .in_valid(v2), .in_ready(rdy2), .mcand(a2), .mplier(b2),
    .busy(busy2), .done(done2), .product(prod2)
  );
  bsmul_ref #(.N(5), .M(3)) ref2 (
    .clk(clk), .rst(rst), .in_valid(v2), .a(a2), .b(b2),
    .e_busy(eb2), .e_done(ed2), .e_prod(ep2)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference model
  always @(negedge clk) begin
    if (!rst) begin
      check(rdy1 == !eb1, "R1 in_ready (16x16)", 64'(rdy1), 64'(!eb1));
      check(busy1 == eb1, "R2 busy (16x16)", 64'(busy1), 64'(eb1));
      check(done1 == ed1, "R3 done (16x16)", 64'(done1), 64'(ed1));
      check(prod1 == ep1, "R4/R8 product (16x16)", 64'(prod1), 64'(ep1));
      check(rdy2 == !eb2, "R1 in_ready (5x3)", 64'(rdy2), 64'(!eb2));
      check(busy2 == eb2, "R2 busy (5x3)", 64'(busy2), 64'(eb2));
      check(done2 == ed2, "R3 done (5x3)", 64'(done2), 64'(ed2));
      check(prod2 == ep2, "R4/R8 product (5x3)", 64'(prod2), 64'(ep2));
    end
  end

  task automatic run1(input logic signed [15:0] a, input logic signed [15:0] b, input string tag);
    logic signed [31:0] exp;
    exp = a * b;
    @(negedge clk); v1 = 1; a1 = a; b1 = b;
    @(negedge clk); v1 = 0;
    while (!done1) @(negedge clk);
    check(prod1 == exp, tag, 64'(prod1), 64'(exp));
  endtask

  task automatic run2(input logic signed [4:0] a, input logic signed [2:0] b);
    logic signed [7:0] exp;
    exp = a * b;
    @(negedge clk); v2 = 1; a2 = a; b2 = b;
    @(negedge clk); v2 = 0;
    while (!done2) @(negedge clk);
    check(prod2 == exp, "R4 exhaustive 5x3", 64'(prod2), 64'(exp));
  endtask

  task automatic run_all();
    logic signed [31:0] ex;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10: state straight after reset
    check(rdy1 == 1'b1, "R10 in_ready after reset", 64'(rdy1), 64'd1);
    check(busy1 == 1'b0, "R10 busy after reset", 64'(busy1), 64'd0);
    check(done1 == 1'b0, "R10 done after reset", 64'(done1), 64'd0);
    check(prod1 == '0, "R10 product after reset", 64'(prod1), 64'd0);

    run1(16'sd0, 16'sd1234, "R4 zero multiplicand");
    run1(16'sd1, -16'sd1, "R4 one times minus one");
    run1(-16'sd1, -16'sd1, "R4 minus one squared");
    run1(16'sd32767, 16'sd32767, "R4 max positive squared");
    run1(16'sd123, -16'sd32768, "R5 most negative multiplier");
    run1(-16'sd32768, -16'sd32768, "R5 both most negative");
    run1(16'sd32767, -16'sd32768, "R5 max pos times most negative");
    run1(-16'sd32768, 16'sd32767, "R6 most negative multiplicand, positive");
    run1(-16'sd32768, -16'sd1, "R6 most negative multiplicand, negative");
    run1(-16'sd32768, 16'sd0, "R6 most negative multiplicand, zero");

    for (int i = 0; i < 24; i++) run1($signed(16'($urandom)), $signed(16'($urandom)), "R4 random");

    // R7 and R9: operands change while busy, then hand-over during done
    @(negedge clk); v1 = 1; a1 = 16'sd300; b1 = -16'sd7;
    @(negedge clk); a1 = -16'sd55; b1 = 16'sd999;
    while (!done1) @(negedge clk);
    ex = 32'(-2100);
    check(prod1 == ex, "R7 operands changed while busy ignored", 64'(prod1), 64'(ex));
    @(negedge clk); v1 = 0;
    check(busy1 == 1'b1, "R9 captured in done cycle", 64'(busy1), 64'd1);
    while (!done1) @(negedge clk);
    ex = 32'(-55 * 999);
    check(prod1 == ex, "R9 back-to-back second result", 64'(prod1), 64'(ex));

    for (int i = -16; i < 16; i++)
      for (int j = -4; j < 4; j++)
        run2(5'(i), 3'(j));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule